// File: doc/BRIEF.md
# Carry-Chained Integer ALU

This block is a purely combinational integer arithmetic and logic unit for a small CPU core. It takes two operands, a four-bit operation code and the carry flag currently held by the core. It returns a result and four updated condition flags. The operations are add, subtract, add and subtract that also fold in the stored carry, the three bitwise operations, three shifts, and signed and unsigned multiply truncated to the operand width.

The carry-chained add and subtract let software build arithmetic wider than one word. The low words are handled with the plain operation, and each higher word uses the chained one so that the carry or borrow moves upward. The block does not choose between a register and an immediate for the second operand. The caller places either one on `op_b`, and every operation behaves the same for both.

The flag vector has a fixed layout: bit 0 carry, bit 1 overflow, bit 2 zero and bit 3 sign. The operand width and the shifter structure are parameters.

Top module: `chain_alu`

## Requirements
- R1: Code 0 (add) gives result = A + B modulo 2^W, and flag bit 0 is the carry out of the top bit.
- R2: Code 1 (add with carry) gives result = A + B + carry_in modulo 2^W, and flag bit 0 is the carry out of that three-term sum.
- R3: Code 2 (subtract) gives result = A − B modulo 2^W, and flag bit 0 is a borrow that is set exactly when A < B as unsigned values.
- R4: Code 3 (subtract with carry) gives result = A − B − carry_in modulo 2^W, and flag bit 0 is set exactly when A < B + carry_in as unsigned values.
- R5: For codes 0 to 3, flag bit 1 is signed two's-complement overflow of the operation. For every other code, flag bit 1 is 0.
- R6: Codes 4, 5 and 6 give A XOR B, A OR B and A AND B, with flag bits 0 and 1 cleared.
- R7: Codes 7, 8 and 9 shift A left logically, right logically and right arithmetically. The shift amount is the low log2(W) bits of B, and the higher bits of B have no effect. Flag bits 0 and 1 are cleared.
- R8: Codes 10 (signed multiply) and 11 (unsigned multiply) give the low W bits of A × B, with flag bits 0 and 1 cleared.
- R9: For every code, flag bit 2 is set exactly when the result is all zeros, and flag bit 3 equals the result's most significant bit.
- R10: carry_in has no effect on the result or flags for any code other than 1 and 3.
- R11: Codes 12 to 15 are unassigned. They give a zero result, with only flag bit 2 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand, from a register or an immediate |
| op_sel | input | 4 | Operation code |
| carry_in | input | 1 | Stored carry flag, used by codes 1 and 3 |
| result | output | WIDTH | Operation result |
| flags | output | 4 | {sign, zero, overflow, carry} |

## Verification
The bench drives two copies of the block side by side. The first uses the default 32-bit width with the staged logarithmic shifter, and covers full-width carry and borrow chains, the most-negative operand and shift amounts whose upper bits of B are set. The second is 8 bits wide with the operator-based shifter. At that width the bench can sweep every value of A for the chained add and subtract, reaching every carry, borrow and overflow boundary. It also exercises the second shifter variant with every shift amount.

// File: rtl/chain_alu_pkg.sv
package chain_alu_pkg;

   localparam int OPC_W = 4;
   localparam int FLG_N = 4;

   localparam int FLG_CARRY = 0;
   localparam int FLG_OVF   = 1;
   localparam int FLG_ZERO  = 2;
   localparam int FLG_SIGN  = 3;

   typedef enum logic [OPC_W-1:0] {
      OPC_ADD  = 4'd0,
      OPC_ADC  = 4'd1,
      OPC_SUB  = 4'd2,
      OPC_SBC  = 4'd3,
      OPC_XOR  = 4'd4,
      OPC_OR   = 4'd5,
      OPC_AND  = 4'd6,
      OPC_SHL  = 4'd7,
      OPC_SHR  = 4'd8,
      OPC_SRA  = 4'd9,
      OPC_MUL  = 4'd10,
      OPC_MULU = 4'd11
   } opc_e;

endpackage

// File: rtl/chain_alu_addsub.sv
module chain_alu_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             is_sub,
   input  logic             chained,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cy,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic             c_eff;
   logic [WIDTH:0]   wide;

   // subtract as a + ~b + 1, minus the borrow when chained
   assign b_eff = is_sub ? ~b : b;
   always_comb begin
      if (is_sub) c_eff = chained ? ~cin : 1'b1;
      else        c_eff = chained ? cin  : 1'b0;
   end

   assign wide = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};
   assign sum  = wide[WIDTH-1:0];
   // carry out of a subtract is "no borrow"; report borrow instead
   assign cy   = is_sub ? ~wide[WIDTH] : wide[WIDTH];
   assign ovf  = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/chain_alu_shift.sv
module chain_alu_shift #(
   parameter int WIDTH   = 32,
   parameter bit STAGED  = 1'b1,
   localparam int SHW    = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] din,
   input  logic [SHW-1:0]   amt,
   input  logic             left,
   input  logic             arith,
   output logic [WIDTH-1:0] dout
);
   logic fill;
   assign fill = arith & din[WIDTH-1];

   generate
      if (STAGED) begin : g_staged
         logic [WIDTH-1:0] st [SHW+1];
         assign st[0] = din;
         for (genvar k = 0; k < SHW; k++) begin : g_stage
            localparam int D = 1 << k;
            logic [WIDTH-1:0] moved;
            assign moved = left ? {st[k][WIDTH-1-D:0], {D{1'b0}}}
                                : {{D{fill}}, st[k][WIDTH-1:D]};
            assign st[k+1] = amt[k] ? moved : st[k];
         end
         assign dout = st[SHW];
      end else begin : g_operator
         logic [2*WIDTH-1:0] ext;
         logic [2*WIDTH-1:0] ext_sh;
         assign ext    = {{WIDTH{fill}}, din};
         assign ext_sh = ext >> amt;
         assign dout   = left ? (din << amt) : ext_sh[WIDTH-1:0];
      end
   endgenerate

endmodule

// File: rtl/chain_alu_mul.sv
module chain_alu_mul #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] prod
);
   // low WIDTH bits of the product are the same for signed and unsigned
   assign prod = a * b;
endmodule

// File: rtl/chain_alu.sv
module chain_alu
   import chain_alu_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter bit SHIFT_STAGED = 1'b1,
   localparam int SHW         = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [OPC_W-1:0] op_sel,
   input  logic             carry_in,
   output logic [WIDTH-1:0] result,
   output logic [FLG_N-1:0] flags
);
   generate
      if (WIDTH < 4 || (1 << SHW) != WIDTH) begin : g_bad_width
         $error("chain_alu: WIDTH must be a power of two of at least 4");
      end
   endgenerate

   logic [WIDTH-1:0] as_sum, sh_out, mul_out;
   logic             as_cy, as_ovf;
   logic             is_sub, chained, sh_left, sh_arith;

   assign is_sub   = (op_sel == OPC_SUB) || (op_sel == OPC_SBC);
   assign chained  = (op_sel == OPC_ADC) || (op_sel == OPC_SBC);
   assign sh_left  = (op_sel == OPC_SHL);
   assign sh_arith = (op_sel == OPC_SRA);

   chain_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a(op_a), .b(op_b), .is_sub(is_sub), .chained(chained), .cin(carry_in),
      .sum(as_sum), .cy(as_cy), .ovf(as_ovf)
   );

   chain_alu_shift #(.WIDTH(WIDTH), .STAGED(SHIFT_STAGED)) u_shift (
      .din(op_a), .amt(op_b[SHW-1:0]), .left(sh_left), .arith(sh_arith),
      .dout(sh_out)
   );

   chain_alu_mul #(.WIDTH(WIDTH)) u_mul (
      .a(op_a), .b(op_b), .prod(mul_out)
   );

   logic c_f, v_f;

   always_comb begin
      result = '0;
      c_f    = 1'b0;
      v_f    = 1'b0;
      case (op_sel)
         OPC_ADD, OPC_ADC, OPC_SUB, OPC_SBC: begin
            result = as_sum;
            c_f    = as_cy;
            v_f    = as_ovf;
         end
         OPC_XOR:                     result = op_a ^ op_b;
         OPC_OR:                      result = op_a | op_b;
         OPC_AND:                     result = op_a & op_b;
         OPC_SHL, OPC_SHR, OPC_SRA:   result = sh_out;
         OPC_MUL, OPC_MULU:           result = mul_out;
         default:                     result = '0;
      endcase
   end

   always_comb begin
      flags            = '0;
      flags[FLG_CARRY] = c_f;
      flags[FLG_OVF]   = v_f;
      flags[FLG_ZERO]  = (result == '0);
      flags[FLG_SIGN]  = result[WIDTH-1];
   end

endmodule

// File: rtl/chain_alu_chk.sv
module chain_alu_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [3:0]       op_sel,
   input logic             carry_in,
   input logic [WIDTH-1:0] result,
   input logic [3:0]       flags
);
   logic [WIDTH:0] add_ref;
   logic           is_arith;
   assign add_ref  = {1'b0, op_a} + {1'b0, op_b};
   assign is_arith = (op_sel <= 4'd3);

   always_comb begin
      p_zero_flag_r9: assert (flags[2] == (result == '0))
         else $error("zero flag disagrees with result");
      p_sign_flag_r9: assert (flags[3] == result[WIDTH-1])
         else $error("sign flag disagrees with result msb");
      if (op_sel == 4'd0) begin
         p_add_sum_r1: assert ({flags[0], result} == add_ref)
            else $error("add sum or carry wrong");
      end
      if (op_sel == 4'd2) begin
         p_sub_borrow_r3: assert (flags[0] == (op_a < op_b))
            else $error("subtract borrow wrong");
      end
      if (op_sel == 4'd1 && !carry_in) begin
         p_adc_nocarry_r2: assert ({flags[0], result} == add_ref)
            else $error("add with clear carry differs from add");
      end
      if (!is_arith) begin
         p_no_overflow_r5: assert (flags[1] == 1'b0)
            else $error("overflow set outside add/subtract");
      end
      if (op_sel >= 4'd12) begin
         p_unassigned_r11: assert (result == '0 && flags == 4'b0100)
            else $error("unassigned code produced output");
      end
   end
endmodule

bind chain_alu chain_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .carry_in(carry_in),
   .result(result), .flags(flags)
);

// File: tb/sim_chain_alu.sv
`timescale 1ns/1ps
module sim_chain_alu;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [31:0] a0, b0, r0;
   logic [3:0]  s0, f0;
   logic        c0;
   logic [7:0]  a1, b1, r1;
   logic [3:0]  s1, f1;
   logic        c1;

   chain_alu #(.WIDTH(32), .SHIFT_STAGED(1'b1)) u0 (
      .op_a(a0), .op_b(b0), .op_sel(s0), .carry_in(c0), .result(r0), .flags(f0));
   chain_alu #(.WIDTH(8), .SHIFT_STAGED(1'b0)) u1 (
      .op_a(a1), .op_b(b1), .op_sel(s1), .carry_in(c1), .result(r1), .flags(f1));

   // independent reference model from the requirements
   function automatic void model(input int w, input int op,
                                 input longint unsigned a, input longint unsigned b,
                                 input bit cin, output longint unsigned r,
                                 output bit [3:0] f);
      longint unsigned mask, s;
      int msb, sh;
      bit c, v, am, bm, rm;
      mask = (64'd1 << w) - 1;
      msb  = w - 1;
      sh   = int'(b & longint'(w - 1));
      c = 0; v = 0; r = 0;
      am = a[msb]; bm = b[msb];
      case (op)
         0, 1: begin
            s = a + b + ((op == 1) ? longint'(cin) : 0);
            r = s & mask; c = s[w];
            rm = r[msb]; v = (am == bm) && (rm != am);
         end
         2, 3: begin
            s = b + ((op == 3) ? longint'(cin) : 0);
            c = a < s;
            r = (a - s) & mask;
            rm = r[msb]; v = (am != bm) && (rm != am);
         end
         4: r = a ^ b;
         5: r = a | b;
         6: r = a & b;
         7: r = (a << sh) & mask;
         8: r = a >> sh;
         9: r = am ? (((a >> sh) | (mask << (w - sh))) & mask) : (a >> sh);
         10, 11: r = (a * b) & mask;
         default: r = 0;
      endcase
      f = {r[msb], (r == 0), v, c};
   endfunction

   task automatic v32(input int op, input logic [31:0] a, input logic [31:0] b,
                      input bit cin, input string req);
      longint unsigned er; bit [3:0] ef;
      @(negedge clk);
      a0 = a; b0 = b; s0 = 4'(op); c0 = cin;
      #1;
      model(32, op, a, b, cin, er, ef);
      n_vec++;
      if (r0 !== er[31:0] || f0 !== ef) begin
         n_bad++;
         $display("FAIL %s op=%0d a=%h b=%h cin=%0b: got %h/%b expected %h/%b",
                  req, op, a, b, cin, r0, f0, er[31:0], ef);
      end
   endtask

   task automatic v8(input int op, input logic [7:0] a, input logic [7:0] b,
                     input bit cin, input string req);
      longint unsigned er; bit [3:0] ef;
      @(negedge clk);
      a1 = a; b1 = b; s1 = 4'(op); c1 = cin;
      #1;
      model(8, op, a, b, cin, er, ef);
      n_vec++;
      if (r1 !== er[7:0] || f1 !== ef) begin
         n_bad++;
         $display("FAIL %s op=%0d a=%h b=%h cin=%0b: got %h/%b expected %h/%b",
                  req, op, a, b, cin, r1, f1, er[7:0], ef);
      end
   endtask

   task automatic t_idle();          // R9 all-zero inputs
      v32(0, 0, 0, 0, "R9");
      v8(0, 0, 0, 0, "R9");
   endtask

   task automatic t_add();           // R1
      v32(0, 32'h0000_0001, 32'h0000_0002, 0, "R1");
      v32(0, 32'hFFFF_FFFF, 32'h0000_0001, 0, "R1");
      v32(0, 32'h8000_0000, 32'h8000_0000, 0, "R1");
      v32(0, 32'h1234_5678, 32'h0FED_CBA8, 0, "R1");
   endtask

   task automatic t_adc();           // R2
      v32(1, 32'hFFFF_FFFF, 32'h0000_0000, 1, "R2");
      v32(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R2");
      v32(1, 32'h0000_0010, 32'h0000_0020, 1, "R2");
      v32(1, 32'h0000_0010, 32'h0000_0020, 0, "R2");
   endtask

   task automatic t_sub();           // R3
      v32(2, 32'h0000_0005, 32'h0000_0003, 0, "R3");
      v32(2, 32'h0000_0003, 32'h0000_0005, 0, "R3");
      v32(2, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, "R3");
   endtask

   task automatic t_sbc();           // R4
      v32(3, 32'h0000_0005, 32'h0000_0005, 1, "R4");
      v32(3, 32'h0000_0006, 32'h0000_0005, 1, "R4");
      v32(3, 32'h0000_0000, 32'hFFFF_FFFF, 1, "R4");
      v32(3, 32'h0000_0000, 32'h0000_0000, 0, "R4");
   endtask

   task automatic t_ovf();           // R5
      v32(0, 32'h7FFF_FFFF, 32'h0000_0001, 0, "R5");
      v32(1, 32'h7FFF_FFFF, 32'h0000_0000, 1, "R5");
      v32(2, 32'h8000_0000, 32'h0000_0001, 0, "R5");
      v32(3, 32'h8000_0000, 32'h0000_0000, 1, "R5");
      v32(2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, "R5");
   endtask

   task automatic t_logic();         // R6
      for (int op = 4; op <= 6; op++) begin
         v32(op, 32'hF0F0_A5A5, 32'h0FF0_5A5A, 1, "R6");
         v32(op, 32'hFFFF_FFFF, 32'h8000_0000, 0, "R6");
      end
   endtask

   task automatic t_shift();         // R7, high bits of B ignored
      for (int op = 7; op <= 9; op++) begin
         for (int sh = 0; sh < 32; sh += 5)
            v32(op, 32'h8765_4321, 32'(sh), 0, "R7");
         v32(op, 32'h8765_4321, 32'hFFFF_FFE3, 1, "R7");
         v32(op, 32'h8000_0000, 32'd31, 0, "R7");
      end
      for (int op = 7; op <= 9; op++)
         for (int sh = 0; sh < 8; sh++)
            v8(op, 8'hB6, 8'(sh) | 8'hF8, 0, "R7");
   endtask

   task automatic t_mul();           // R8
      v32(10, 32'hFFFF_FFFF, 32'h0000_0003, 0, "R8");
      v32(11, 32'h0001_0000, 32'h0001_0000, 0, "R8");
      v32(10, 32'h1234_5678, 32'h9ABC_DEF0, 1, "R8");
      v32(11, 32'h8000_0001, 32'h8000_0001, 0, "R8");
   endtask

   task automatic t_cin_ignored();   // R10
      for (int op = 0; op < 16; op++) begin
         if (op == 1 || op == 3) continue;
         v32(op, 32'hC3C3_0F0F, 32'h0000_0007, 1, "R10");
      end
   endtask

   task automatic t_unassigned();    // R11
      for (int op = 12; op < 16; op++) begin
         v32(op, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R11");
         v8(op, 8'h80, 8'h01, 0, "R11");
      end
   endtask

   task automatic t_narrow_sweep();  // R2 R4 R5 at 8 bits, every A
      for (int a = 0; a < 256; a++) begin
         v8(1, 8'(a), 8'h7F, 1, "R2");
         v8(3, 8'(a), 8'h80, 1, "R4");
         v8(0, 8'(a), 8'h01, 0, "R5");
      end
   endtask

   initial begin
      a0 = '0; b0 = '0; s0 = '0; c0 = 1'b0;
      a1 = '0; b1 = '0; s1 = '0; c1 = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_idle();
      t_add();
      t_adc();
      t_sub();
      t_sbc();
      t_ovf();
      t_logic();
      t_shift();
      t_mul();
      t_cin_ignored();
      t_unassigned();
      t_narrow_sweep();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run hung, got no finish expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule